// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard logic of a five-stage pipeline (fetch, decode/register read, execute, memory, writeback). It looks at the two source register numbers of the instruction in decode and compares them with the destinations of the two older instructions ahead of it. From that comparison it produces the select code for each ALU operand multiplexer. It also detects a load whose result the very next instruction needs, and requests a one-cycle stall.

The select codes are worked out one stage early and registered. They reach the execute stage in the same cycle as the instruction they belong to. In that cycle the producer that was in execute sits in the EX/MEM register, and the producer that was in memory sits in the MEM/WB register. The register file writes in the first half of a cycle and reads in the second half, so a producer three instructions ahead needs no bypass.

The `FORWARD_EN` parameter chooses the variant. With bypassing removed, the unit never selects a bypass path and instead holds a dependent instruction in decode until every producer it depends on has reached writeback.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both operand selects are 00 after that edge.
- R2: Each operand select uses the codes 00 = register file, 10 = EX/MEM, 01 = MEM/WB, and never 11. A decode source equal to the writing destination in execute gives 10 on the next cycle.
- R3: A decode source equal to the writing destination in the memory stage, and not also matched in execute, gives 01 on the next cycle.
- R4: When both the execute and the memory destinations match the same source, the select is 10 (the younger result wins).
- R5: Register 0 never matches. A stage whose write enable is low never matches.
- R6: When the execute stage holds a writing load whose nonzero destination equals either decode source, `pc_hold`, `ifid_hold` and `idex_bubble` are all high in that same cycle. Otherwise all three are low (bypass variant).
- R7: In the cycle after a stall request, both operand selects are 00, because the bubble carries no operands.
- R8: A load in the memory stage that a decode source depends on causes no stall and gives select 01. A load in execute that no decode source uses causes no stall.
- R9: With `FORWARD_EN` = 0, both selects stay 00. The three stall outputs are high whenever a decode source matches a writing, nonzero destination in execute or in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_rs_a | input | REG_ADDR_W | First source register of the instruction in decode |
| id_rs_b | input | REG_ADDR_W | Second source register of the instruction in decode |
| ex_rd | input | REG_ADDR_W | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_ADDR_W | Destination register of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| fwd_a | output | 2 | Select for ALU operand A of the instruction now in execute |
| fwd_b | output | 2 | Select for ALU operand B of the instruction now in execute |
| pc_hold | output | 1 | Keep the program counter this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register this cycle |
| idex_bubble | output | 1 | Load a bubble into ID/EX this cycle |

## Verification
Directed patterns place a dependency on operand A only, on operand B only, on both older stages at once, on register 0, and on a stage with its write enable low. Together these separate the distance-1 code, the distance-2 code, the priority between them, and the suppression rules. A load-use pair on each operand is followed by the replayed instruction, which shows that the stall fires and the bubble clears the selects. That replayed instruction also shows that the same load one stage later is bypassed from MEM/WB rather than stalled. Random traffic over a small register range produces frequent collisions in both the bypass variant and the no-bypass variant, and both are compared against reference functions.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    // Younger producer (execute at decode time) has priority.
    function automatic fwd_sel_e fwd_pick(input logic hit_ex, input logic hit_mem);
        if (hit_ex)       return FWD_EXMEM;
        else if (hit_mem) return FWD_MEMWB;
        else              return FWD_RF;
    endfunction

endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] ex_rd,
    input  logic                  ex_wen,
    input  logic [REG_ADDR_W-1:0] mem_rd,
    input  logic                  mem_wen,
    output logic                  hit_ex,
    output logic                  hit_mem
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit_ex  = ex_wen  && (ex_rd  != ZERO_REG) && (ex_rd  == src);
        hit_mem = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
    end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
    parameter int N_SRC      = 2,
    parameter bit FORWARD_EN = 1'b1
) (
    input  logic [N_SRC-1:0] hit_ex,
    input  logic [N_SRC-1:0] hit_mem,
    input  logic             ex_load,
    output logic             stall
);
    localparam logic NO_BYPASS = !FORWARD_EN;

    logic [N_SRC-1:0] must_wait;

    // Bypass variant: only a load one ahead cannot be covered.
    // No-bypass variant: any producer not yet in writeback blocks decode.
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            must_wait[i] = (hit_ex[i] && (ex_load || NO_BYPASS)) ||
                           (hit_mem[i] && NO_BYPASS);
        end
        stall = |must_wait;
    end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_hazard_pkg::*;
#(
    parameter int REG_ADDR_W = 5,
    parameter bit FORWARD_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] id_rs_a,
    input  logic [REG_ADDR_W-1:0] id_rs_b,
    input  logic [REG_ADDR_W-1:0] ex_rd,
    input  logic                  ex_wen,
    input  logic                  ex_load,
    input  logic [REG_ADDR_W-1:0] mem_rd,
    input  logic                  mem_wen,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b,
    output logic                  pc_hold,
    output logic                  ifid_hold,
    output logic                  idex_bubble
);
    localparam int N_SRC = 2;

    logic [N_SRC-1:0][REG_ADDR_W-1:0] srcs;
    logic [N_SRC-1:0]                 hit_ex;
    logic [N_SRC-1:0]                 hit_mem;
    logic                             stall;
    fwd_sel_e                         sel_d [N_SRC];
    fwd_sel_e                         sel_q [N_SRC];

    assign srcs = {id_rs_b, id_rs_a};

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        fwd_src_match #(.REG_ADDR_W(REG_ADDR_W)) u_match (
            .src     (srcs[i]),
            .ex_rd   (ex_rd),
            .ex_wen  (ex_wen),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .hit_ex  (hit_ex[i]),
            .hit_mem (hit_mem[i])
        );

        if (FORWARD_EN) begin : g_bypass
            assign sel_d[i] = stall ? FWD_RF : fwd_pick(hit_ex[i], hit_mem[i]);
        end else begin : g_nobypass
            assign sel_d[i] = FWD_RF;
        end

        always_ff @(posedge clk) begin
            if (rst) sel_q[i] <= FWD_RF;
            else     sel_q[i] <= sel_d[i];
        end
    end

    hz_stall_detect #(.N_SRC(N_SRC), .FORWARD_EN(FORWARD_EN)) u_stall (
        .hit_ex  (hit_ex),
        .hit_mem (hit_mem),
        .ex_load (ex_load),
        .stall   (stall)
    );

    assign fwd_a       = sel_q[0];
    assign fwd_b       = sel_q[1];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
    parameter int REG_ADDR_W = 5,
    parameter bit FORWARD_EN = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [REG_ADDR_W-1:0] id_rs_a,
    input logic [REG_ADDR_W-1:0] id_rs_b,
    input logic [REG_ADDR_W-1:0] ex_rd,
    input logic                  ex_wen,
    input logic                  ex_load,
    input logic [REG_ADDR_W-1:0] mem_rd,
    input logic                  mem_wen,
    input logic [1:0]            fwd_a,
    input logic [1:0]            fwd_b,
    input logic                  pc_hold,
    input logic                  ifid_hold,
    input logic                  idex_bubble
);
    localparam logic [REG_ADDR_W-1:0] Z = '0;

    p_code_r2: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (ex_rd == Z && mem_rd == Z) |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

    p_nowen_r5: assert property (@(posedge clk) disable iff (rst)
        (!ex_wen && !mem_wen) |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

    p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

    if (FORWARD_EN) begin : g_bypass
        p_exmem_r4: assert property (@(posedge clk) disable iff (rst)
            (!idex_bubble && ex_wen && ex_rd != Z && id_rs_a == ex_rd) |=> fwd_a == 2'b10);

        p_memwb_r3: assert property (@(posedge clk) disable iff (rst)
            (!idex_bubble && mem_wen && mem_rd != Z && id_rs_b == mem_rd &&
             !(ex_wen && ex_rd == id_rs_b)) |=> fwd_b == 2'b01);

        p_loaduse_r6: assert property (@(posedge clk) disable iff (rst)
            pc_hold |-> (ex_load && ex_wen && ex_rd != Z &&
                         (ex_rd == id_rs_a || ex_rd == id_rs_b)));

        p_hold_pair_r6: assert property (@(posedge clk) disable iff (rst)
            (ex_load && ex_wen && ex_rd != Z && ex_rd == id_rs_b) |-> (ifid_hold && idex_bubble));
    end else begin : g_nobypass
        p_nosel_r9: assert property (@(posedge clk) disable iff (rst)
            (fwd_a == 2'b00 && fwd_b == 2'b00));

        p_wait_r9: assert property (@(posedge clk) disable iff (rst)
            (mem_wen && mem_rd != Z && mem_rd == id_rs_a) |-> pc_hold);
    end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(
    .REG_ADDR_W (REG_ADDR_W),
    .FORWARD_EN (FORWARD_EN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .id_rs_a     (id_rs_a),
    .id_rs_b     (id_rs_b),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .mem_rd      (mem_rd),
    .mem_wen     (mem_wen),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble)
);

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] id_rs_a = '0, id_rs_b = '0, ex_rd = '0, mem_rd = '0;
    logic          ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0;
    logic [1:0]    fwd_a, fwd_b, nf_fwd_a, nf_fwd_b;
    logic          pc_hold, ifid_hold, idex_bubble;
    logic          nf_pc_hold, nf_ifid_hold, nf_idex_bubble;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic [1:0] exp_a = 2'b00, exp_b = 2'b00;
    string prev_tag = "R1";

    always #5 clk = ~clk;

    fwd_hazard_unit #(.REG_ADDR_W(AW), .FORWARD_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    fwd_hazard_unit #(.REG_ADDR_W(AW), .FORWARD_EN(1'b0)) u_dut_nf (
        .clk(clk), .rst(rst), .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .fwd_a(nf_fwd_a), .fwd_b(nf_fwd_b), .pc_hold(nf_pc_hold),
        .ifid_hold(nf_ifid_hold), .idex_bubble(nf_idex_bubble)
    );

    function automatic logic [1:0] ref_sel(input logic [AW-1:0] rs, input logic [AW-1:0] er,
                                           input logic ew, input logic [AW-1:0] mr, input logic mw);
        if (ew && er != '0 && er == rs)      return 2'b10;
        else if (mw && mr != '0 && mr == rs) return 2'b01;
        else                                 return 2'b00;
    endfunction

    function automatic logic hit(input logic [AW-1:0] rs, input logic [AW-1:0] rd, input logic w);
        return w && rd != '0 && rd == rs;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                         input logic [AW-1:0] er, input logic ew, input logic el,
                         input logic [AW-1:0] mr, input logic mw, input string tag);
        logic s_f, s_n;
        @(negedge clk);
        chk(prev_tag, "fwd_a", fwd_a, exp_a);
        chk(prev_tag, "fwd_b", fwd_b, exp_b);
        chk("R9", "nf_fwd_a", nf_fwd_a, 0);
        chk("R9", "nf_fwd_b", nf_fwd_b, 0);
        id_rs_a = ra; id_rs_b = rb; ex_rd = er; ex_wen = ew; ex_load = el;
        mem_rd = mr; mem_wen = mw;
        #1;
        s_f = el && (hit(ra, er, ew) || hit(rb, er, ew));
        s_n = hit(ra, er, ew) || hit(rb, er, ew) || hit(ra, mr, mw) || hit(rb, mr, mw);
        chk("R6", "pc_hold", pc_hold, s_f);
        chk("R6", "ifid_hold", ifid_hold, s_f);
        chk("R6", "idex_bubble", idex_bubble, s_f);
        chk("R9", "nf_pc_hold", nf_pc_hold, s_n);
        chk("R9", "nf_idex_bubble", nf_idex_bubble, s_n);
        exp_a = s_f ? 2'b00 : ref_sel(ra, er, ew, mr, mw);
        exp_b = s_f ? 2'b00 : ref_sel(rb, er, ew, mr, mw);
        prev_tag = s_f ? "R7" : tag;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // Inputs that would select a bypass if reset were not applied.
        id_rs_a = 5'd3; id_rs_b = 5'd4; ex_rd = 5'd3; ex_wen = 1'b1;
        mem_rd = 5'd4; mem_wen = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "fwd_a reset", fwd_a, 0);
        chk("R1", "fwd_b reset", fwd_b, 0);
        id_rs_a = '0; id_rs_b = '0; ex_rd = '0; ex_wen = 1'b0; mem_rd = '0; mem_wen = 1'b0;
        rst = 1'b0;

        apply(5'd5, 5'd0, 5'd5, 1, 0, 5'd0, 0, "R2");
        apply(5'd0, 5'd7, 5'd0, 0, 0, 5'd7, 1, "R3");
        apply(5'd4, 5'd4, 5'd4, 1, 0, 5'd4, 1, "R4");
        apply(5'd0, 5'd0, 5'd0, 1, 0, 5'd0, 1, "R5");
        apply(5'd6, 5'd6, 5'd6, 0, 0, 5'd6, 0, "R5");
        apply(5'd9, 5'd1, 5'd9, 1, 1, 5'd2, 1, "R6");
        apply(5'd9, 5'd1, 5'd0, 0, 0, 5'd9, 1, "R8");
        apply(5'd3, 5'd8, 5'd8, 1, 1, 5'd0, 0, "R6");
        apply(5'd3, 5'd8, 5'd0, 0, 0, 5'd8, 1, "R8");
        apply(5'd2, 5'd3, 5'd5, 1, 1, 5'd2, 1, "R8");
        apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, "R5");

        for (int k = 0; k < 400; k++) begin
            apply(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                  AW'($urandom_range(0, 3)), 1'($urandom), "R2");
        end
        apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, "R5");
        apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, "R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule